// File: doc/BRIEF.md
# Clock Rate Trim Unit

The block takes a 32.768 kHz reference, delivered as a one-cycle clock enable in the system clock domain, and divides it down to a one-second tick. A crystal that runs fast or slow makes that tick drift. The block compensates by changing how many reference pulses the divider counts in one particular second. The oscillator itself is never adjusted.

Corrections happen once per correction window. A window lasts either a short number of seconds (20 by default) or a long number (60 by default). In the last second of each window, the divider counts a few extra reference pulses (the clock is slowed down) or a few fewer (the clock is sped up). Each step is worth two reference pulses. Over a 20 s window this gives about 3.05 ppm per step, and over a 60 s window about 1.02 ppm per step.

The setting comes from an 8-bit trim word:
- Bit 7 picks the window length.
- Bit 6 picks the direction.
- Bits 5:0 give the number of steps.

The block latches a new trim word only when a window starts. The raw reference pulses are passed straight through to a separate output and are never affected by the correction.

Top module: `clk_rate_trim`

## Requirements
- R1: The reset is synchronous and active low. While it is held, `tick_o` is 0 and the divider count and the second-within-window index return to zero. The trim word on `trim_i` at the reset edge becomes the active setting for the first window.
- R2: `ref_o` equals `ref_en_i` in every cycle, whatever the trim setting is.
- R3: `tick_o` is a single-cycle pulse. It is high in the clock cycle after the edge that samples the last reference enable of a second. An uncorrected second lasts `REF_HZ` enables.
- R4: Active setting bit 7 = 0 makes a window `FINE_SECS` seconds long. Bit 7 = 1 makes it `COARSE_SECS` seconds long. Windows follow one another with no gap, starting at reset.
- R5: Only the final second of a window is corrected. Every other second lasts exactly `REF_HZ` enables.
- R6: With bit 6 = 0 and a step count n = bits 5:0, the final second lasts `REF_HZ + 2n` enables, which slows the clock.
- R7: With bit 6 = 1 and a step count n, the final second lasts `REF_HZ - 2n` enables, which speeds the clock up.
- R8: A step count of zero disables correction. This covers 00h and any word whose bits 5:0 are zero. All seconds then last `REF_HZ` enables.
- R9: A change on `trim_i` has no effect on the current window. The value sampled at the clock edge that ends a window's final second becomes the setting for the next window. A write made in the cycle where `tick_o` is high therefore waits one full window.
- R10: The divider advances only in cycles where `ref_en_i` is 1. Gaps between enables stretch the tick spacing in clock cycles but do not change the count of enables.
- R11: The full step range 0 to 63 works in both directions, giving up to 126 enables added or removed per window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en_i | input | 1 | 32.768 kHz reference pulse as a one-cycle clock enable |
| trim_i | input | 8 | Trim word: bit 7 window length, bit 6 direction, bits 5:0 step count |
| tick_o | output | 1 | Corrected one-second tick, one cycle wide |
| ref_o | output | 1 | Unaltered reference passthrough |

## Verification
Two events can fall in the same cycle: the tick that closes a correction window and a change to the trim word. Because the new setting is latched on that same edge, a write at that moment could be taken early.

The bench writes every new trim word in the very cycle where `tick_o` is high. Its model predicts that the previous word still governs the whole window that has just begun. Each second's length in enables is compared against that prediction, and seconds that run under a not-yet-active word are tagged so they can be identified.

The same comparison is repeated with gapped reference enables. It is also repeated at the largest step count in both directions.

// File: rtl/clk_trim_pkg.sv
// Package: shared types and helpers for the clock rate trim unit.
// Assumes the trim word layout {window select, direction, 6-bit step count}.
package clk_trim_pkg;

    // Largest step count the 6-bit field can carry.
    localparam int STEP_MAX = 63;

    // Active correction setting; bit 7 window, bit 6 direction, bits 5:0 steps.
    typedef struct packed {
        logic       coarse;    // 1: long window, 0: short window
        logic       speed_up;  // 1: remove enables, 0: add enables
        logic [5:0] steps;     // number of correction steps, 0 = none
    } trim_cfg_t;

    // Larger of two integers, used for counter sizing.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trim_cfg_latch.sv
// Module: holds the trim setting that governs the current window.
// Assumes win_start pulses on the edge that closes a window's final second.
// The setting is loaded at reset and at each window start, never in between.
module trim_cfg_latch
    import clk_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      win_start,
    input  trim_cfg_t trim_in,
    output trim_cfg_t active
);

    // Capture the requested setting at reset or when a new window begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= trim_in;
        end else if (win_start) begin
            active <= trim_in;
        end
    end

    // R9: setting frozen for the whole window
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> $stable(active));

endmodule

// File: rtl/trim_window_ctr.sv
// Module: counts seconds inside a correction window.
// Assumes sec_wrap is a one-cycle pulse per completed second and that the
// window select only changes together with a window start.
// Window lengths must be at least 2 seconds.
module trim_window_ctr #(
    parameter int FINE_SECS   = 20,
    parameter int COARSE_SECS = 60,
    parameter int SEC_W       = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_wrap,
    input  logic coarse,
    output logic last_sec,
    output logic win_start
);

    logic [SEC_W-1:0] sec_idx;
    logic [SEC_W-1:0] win_last;

    // Index of the final second for the selected window length.
    always_comb begin
        win_last = coarse ? SEC_W'(COARSE_SECS - 1) : SEC_W'(FINE_SECS - 1);
    end

    // Flag the final second and the edge at which the window closes.
    always_comb begin
        last_sec  = (sec_idx == win_last);
        win_start = sec_wrap && last_sec;
    end

    // Step the second index, wrapping to zero at the end of a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_idx <= '0;
        end else if (win_start) begin
            sec_idx <= '0;
        end else if (sec_wrap) begin
            sec_idx <= sec_idx + 1'b1;
        end
    end

    // R4: index never runs past the selected window length
    assert_sec_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_idx <= win_last);

endmodule

// File: rtl/trim_prescaler.sv
// Module: variable-period divider from reference enables to a second tick.
// Assumes REF_HZ exceeds the largest removal by at least 2, so every second
// is at least two enables long, and that last_sec and cfg change only on a wrap.
module trim_prescaler
    import clk_trim_pkg::*;
#(
    parameter int REF_HZ      = 32768,
    parameter int STEP_CYCLES = 2,
    parameter int CNT_W       = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_en,
    input  logic      last_sec,
    input  trim_cfg_t cfg,
    output logic      sec_wrap,
    output logic      tick_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    int               adj;

    // Pick this second's length: nominal, or corrected in the final second.
    always_comb begin
        adj    = int'(cfg.steps) * STEP_CYCLES;
        period = CNT_W'(REF_HZ);
        if (last_sec && (cfg.steps != '0)) begin
            period = cfg.speed_up ? CNT_W'(REF_HZ - adj) : CNT_W'(REF_HZ + adj);
        end
    end

    // A second completes on the enable that reaches the chosen length.
    always_comb begin
        sec_wrap = ref_en && (cnt == period - 1'b1);
    end

    // Count reference enables, restarting at each completed second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sec_wrap) begin
            cnt <= '0;
        end else if (ref_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Register the tick so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_o <= 1'b0;
        end else begin
            tick_o <= sec_wrap;
        end
    end

    // R5: count stays inside the current second's length
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period);

    // R10: count holds when no reference enable arrives
    assert_hold_no_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(cnt));

    // R10: every tick follows a sampled enable
    assert_tick_after_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(ref_en));

    // R3: tick is one cycle wide
    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/clk_rate_trim.sv
// Module: top of the clock rate trim unit.
// Divides a reference enable into a one-second tick and lengthens or shortens
// the final second of each correction window according to the trim word.
// Assumes ref_en_i is a one-cycle enable in the clk domain.
module clk_rate_trim
    import clk_trim_pkg::*;
#(
    parameter int REF_HZ      = 32768,
    parameter int FINE_SECS   = 20,
    parameter int COARSE_SECS = 60,
    parameter int STEP_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en_i,
    input  logic [7:0] trim_i,
    output logic       tick_o,
    output logic       ref_o
);

    localparam int MAX_ADJ = STEP_CYCLES * STEP_MAX;
    localparam int CNT_W   = $clog2(REF_HZ + MAX_ADJ + 1);
    localparam int SEC_W   = $clog2(max2(FINE_SECS, COARSE_SECS));

    trim_cfg_t trim_req;
    trim_cfg_t active;
    logic      sec_wrap;
    logic      last_sec;
    logic      win_start;

    // Reinterpret the raw trim word as its fields.
    always_comb begin
        trim_req = trim_cfg_t'(trim_i);
    end

    // Reference passthrough, untouched by correction.
    always_comb begin
        ref_o = ref_en_i;
    end

    trim_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_start (win_start),
        .trim_in   (trim_req),
        .active    (active)
    );

    trim_window_ctr #(
        .FINE_SECS   (FINE_SECS),
        .COARSE_SECS (COARSE_SECS),
        .SEC_W       (SEC_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_wrap  (sec_wrap),
        .coarse    (active.coarse),
        .last_sec  (last_sec),
        .win_start (win_start)
    );

    trim_prescaler #(
        .REF_HZ      (REF_HZ),
        .STEP_CYCLES (STEP_CYCLES),
        .CNT_W       (CNT_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en_i),
        .last_sec (last_sec),
        .cfg      (active),
        .sec_wrap (sec_wrap),
        .tick_o   (tick_o)
    );

endmodule

// File: tb/clk_rate_trim_tb.sv
// Bench: scoreboard of second lengths measured in reference enables.
module clk_rate_trim_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int REF_HZ      = 256;
    localparam int FINE_SECS   = 3;
    localparam int COARSE_SECS = 5;
    localparam int STEP_CYCLES = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en_i = 1'b0;
    logic [7:0] trim_i = 8'h00;
    logic       tick_o;
    logic       ref_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    gap_mode = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    // Driver model state.
    logic [7:0] lat;
    int         sidx;
    bit         first;

    clk_rate_trim #(
        .REF_HZ      (REF_HZ),
        .FINE_SECS   (FINE_SECS),
        .COARSE_SECS (COARSE_SECS),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en_i (ref_en_i),
        .trim_i   (trim_i),
        .tick_o   (tick_o),
        .ref_o    (ref_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference enable source: continuous, or two of every three cycles.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            #1;
            ph++;
            ref_en_i = gap_mode ? ((ph % 3) != 0) : 1'b1;
        end
    end

    // Monitor: measure enables per second and compare with the queue.
    initial begin
        int cnt;
        bit prev_tick;
        cnt = 0;
        prev_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                checks++;
                if (tick_o !== 1'b0) begin
                    errors++;
                    $display("FAIL R1 tick during reset: actual %0b expected 0", tick_o);
                end
                cnt = 0;
                prev_tick = 1'b0;
            end else begin
                checks++;
                if (ref_o !== ref_en_i) begin
                    errors++;
                    $display("FAIL R2 passthrough: actual %0b expected %0b", ref_o, ref_en_i);
                end
                if (tick_o === 1'b1) begin
                    checks++;
                    if (prev_tick) begin
                        errors++;
                        $display("FAIL R3 tick width: actual 2+ cycles expected 1");
                    end else if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R3 unexpected tick: actual %0d enables expected none", cnt);
                    end else begin
                        int    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (cnt != e) begin
                            errors++;
                            $display("FAIL %s second length: actual %0d expected %0d", t, cnt, e);
                        end
                    end
                    cnt = 0;
                end
                cnt += int'(ref_en_i);
                prev_tick = (tick_o === 1'b1);
            end
        end
    end

    // Driver: push the expected length of each second, then wait for its tick.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            int    wlen;
            int    st;
            int    e;
            string tg;
            wlen = lat[7] ? COARSE_SECS : FINE_SECS;
            st   = int'(lat[5:0]);
            e    = REF_HZ;
            tg   = "R3";
            if (sidx == wlen - 1) begin
                if (st != 0) begin
                    e  = lat[6] ? REF_HZ - STEP_CYCLES * st : REF_HZ + STEP_CYCLES * st;
                    tg = lat[6] ? "R7 R4 R5" : "R6 R4 R5";
                    if (st == 63) tg = {tg, " R11"};
                end else begin
                    tg = "R8 R4";
                end
            end else begin
                tg = "R5 R3";
            end
            if (first) tg = {tg, " R1"};
            if (gap_mode) tg = {tg, " R10"};
            if (lat != trim_i) tg = {tg, " R9"};
            exp_q.push_back(e);
            tag_q.push_back(tg);
            do @(negedge clk); while (tick_o !== 1'b1);
            first = 1'b0;
            sidx++;
            if (sidx == wlen) begin
                sidx = 0;
                lat  = trim_i;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus sequence; every trim write lands in a tick-high cycle.
    initial begin
        trim_i = 8'h42;            // R1: loaded at reset, short window, fast 2
        lat    = 8'h42;
        sidx   = 0;
        first  = 1'b1;
        rst_n  = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run(4);
        trim_i = 8'h00;            // R8, R9
        run(6);
        trim_i = 8'h05;            // R6
        run(4);
        trim_i = 8'h3F;            // R11 slow
        run(6);
        trim_i = 8'h7F;            // R11 fast, R7
        run(6);
        trim_i = 8'h85;            // R4 long window
        run(10);
        gap_mode = 1'b1;           // R10
        trim_i = 8'hC0;            // R8 with nonzero upper bits
        run(6);
        trim_i = 8'hFF;
        run(10);
        gap_mode = 1'b0;
        trim_i = 8'h43;
        run(6);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3 pending seconds: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule